// File: doc/BRIEF.md
# Masked Chip-Select Timing Generator

This block decodes a single external memory bank and produces its active-low chip-select and write-enable strobes. At the start of each access it takes the bus address, a 3-bit address-type code and a read/write flag. It compares the address and the type code against a programmed base address and base type. Each comparison has its own per-bit mask, and a mask bit of 1 means that bit takes part in the comparison. Because the address mask may hold any bit pattern, one bank can answer in several separate regions of the address map.

The block runs on a clock at four times the bus clock, so each of its cycles is one quarter of a bus clock. A chip-select setup field delays assertion by zero, one or two quarters after the address becomes valid. An early-negation bit pulls the trailing edge of both strobes in by one quarter. The access length comes from an input counted in whole bus clocks. The match result and all timing settings are captured when the access is accepted. Configuration arrives on plain inputs, so changes only affect the next access.

Quarter numbering: the fast-clock edge that samples `acc_start` high accepts the access. The fast-clock period that follows this edge is quarter 0, the next one is quarter 1, and so on. An access of length L (with `acc_len` = 0 treated as 1) occupies quarters 0 to 4L-1.

Top module: `cs_timing_gen`

## Requirements
- R1: The address matches when `((acc_addr ^ cfg_base) & cfg_amask) == 0`. A mask bit of 1 compares that bit and a mask bit of 0 ignores it. Any non-contiguous mask pattern is honoured bit by bit.
- R2: The 3-bit type code matches when `((acc_type ^ cfg_tbase) & cfg_tmask) == 0`. A set type-mask bit includes that bit in the comparison. With `cfg_tmask` = 0 the type code never affects the result. A hit needs both the address and the type to match, and `acc_hit` shows the latched hit from quarter 0 to the end of the access.
- R3: The setup code `cfg_setup` sets the first quarter in which `cs_n` is low: 2'b00 gives quarter 0, 2'b10 gives quarter 1, and 2'b11 gives quarter 2. The reserved code 2'b01 behaves exactly like 2'b00.
- R4: With `cfg_early` = 0 the strobes stay low through quarter 4L-1 and are high again in quarter 4L. `acc_busy` is high in quarters 0 to 4L-1 exactly. An `acc_len` of 0 gives the same result as 1.
- R5: With `cfg_early` = 1 the last low quarter of `cs_n` and `we_n` is 4L-2. The length of the access (`acc_busy`) does not change.
- R6: On write accesses (`acc_write` = 1), `we_n` has the same waveform as `cs_n`. On reads, `we_n` stays high.
- R7: The hit decision, the write flag, the setup code, the early bit and the length are captured at the accepting edge. Changes on the configuration or address inputs during an access have no effect on that access.
- R8: An `acc_start` sampled while busy is ignored, except when it is sampled in the final quarter 4L-1. In that case it starts a new access whose quarter 0 follows immediately.
- R9: On a miss, `cs_n` and `we_n` stay high for the whole access, while `acc_busy` still runs for 4L quarters.
- R10: While `rst` is high and after it is released, `cs_n` = 1, `we_n` = 1, `acc_busy` = 0 and `acc_hit` = 0 until an access is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-phase clock, four times the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_start | input | 1 | Address valid, requests a new access |
| acc_addr | input | AW | Bus address |
| acc_type | input | 3 | Address-type code |
| acc_write | input | 1 | 1 for a write access |
| acc_len | input | LW | Access length in bus clocks (0 means 1) |
| cfg_base | input | AW | Bank base address |
| cfg_amask | input | AW | Address compare mask, 1 = compare |
| cfg_tbase | input | 3 | Base type code |
| cfg_tmask | input | 3 | Type compare mask, 1 = compare |
| cfg_setup | input | 2 | Chip-select setup code |
| cfg_early | input | 1 | Negate strobes one quarter early |
| cs_n | output | 1 | Chip-select, active low |
| we_n | output | 1 | Write-enable, active low |
| acc_busy | output | 1 | Access in progress |
| acc_hit | output | 1 | Latched hit of the current access |

## Verification
The bench goes after single-bit mask errors with a walking bit over the address mask. It also runs an exhaustive sweep of type mask, type base and type code. These catch a mask with inverted polarity or a bit that is dropped from the comparison, which would show up as hits on foreign addresses or missed hits. Every setup code is run with both negation settings, for one and two bus clock accesses. A design that treats the reserved code as its own delay, or that counts the setup from the wrong quarter, puts the falling edge in the wrong quarter. A design that pulls negation in on the wrong edge would either shorten the access or leave the strobe low into the next period. Back-to-back starts, starts in mid-access and configuration changes in mid-access are also checked. These expose a design that restarts its timer, drops the second access, or recomputes the hit or the setup from the live inputs.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int TYPE_W = 3;

    typedef enum logic [1:0] {
        SU_NONE    = 2'b00,
        SU_RSVD    = 2'b01,
        SU_QUARTER = 2'b10,
        SU_HALF    = 2'b11
    } setup_e;

    // Settings frozen for the life of one access
    typedef struct packed {
        logic       hit;
        logic       wr;
        logic [1:0] lead;   // quarters from address valid to strobe
        logic       early;  // trailing edge pulled in by one quarter
    } acc_ctx_t;

    // Reserved code folds onto the zero-delay case
    function automatic logic [1:0] setup_quarters(setup_e code);
        case (code)
            SU_QUARTER: return 2'd1;
            SU_HALF:    return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/cs_match.sv
module cs_match
    import cs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0]     addr,
    input  logic [AW-1:0]     base,
    input  logic [AW-1:0]     amask,
    input  logic [TYPE_W-1:0] atype,
    input  logic [TYPE_W-1:0] tbase,
    input  logic [TYPE_W-1:0] tmask,
    output logic              hit
);

    logic [AW-1:0]     addr_diff;
    logic [TYPE_W-1:0] type_diff;

    // One qualified difference flag per address bit
    for (genvar i = 0; i < AW; i++) begin : g_abit
        assign addr_diff[i] = amask[i] & (addr[i] ^ base[i]);
    end

    for (genvar j = 0; j < TYPE_W; j++) begin : g_tbit
        assign type_diff[j] = tmask[j] & (atype[j] ^ tbase[j]);
    end

    assign hit = ~(|addr_diff) & ~(|type_diff);

endmodule

// File: rtl/cs_seq.sv
module cs_seq
    import cs_pkg::*;
#(
    parameter int LW = 3,
    parameter int QW = LW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_start,
    input  logic          hit_in,
    input  logic          wr_in,
    input  logic [1:0]    setup_in,
    input  logic          early_in,
    input  logic [LW-1:0] len_in,
    output logic          busy,
    output acc_ctx_t      ctx_q,
    output logic          nxt_live,
    output logic [QW-1:0] nxt_q,
    output acc_ctx_t      nxt_ctx,
    output logic [QW-1:0] nxt_last
);

    logic [QW-1:0] qcnt;
    logic [QW-1:0] last_q;
    logic          final_q;
    logic          accept;
    logic [LW-1:0] len_eff;
    logic [QW-1:0] new_last;
    acc_ctx_t      new_ctx;

    assign final_q  = busy && (qcnt == last_q);
    assign accept   = acc_start && (!busy || final_q);

    assign len_eff  = (len_in == '0) ? LW'(1) : len_in;
    assign new_last = {len_eff - LW'(1), 2'b11};

    always_comb begin
        new_ctx.hit   = hit_in;
        new_ctx.wr    = wr_in;
        new_ctx.lead  = setup_quarters(setup_e'(setup_in));
        new_ctx.early = early_in;
    end

    // Look-ahead view of the quarter that starts at the coming edge
    assign nxt_live = accept || (busy && !final_q);
    assign nxt_q    = accept ? '0 : qcnt + QW'(1);
    assign nxt_ctx  = accept ? new_ctx : ctx_q;
    assign nxt_last = accept ? new_last : last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            qcnt   <= '0;
            last_q <= '0;
            ctx_q  <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            qcnt   <= '0;
            last_q <= new_last;
            ctx_q  <= new_ctx;
        end else if (busy) begin
            if (final_q) begin
                busy <= 1'b0;
            end else begin
                qcnt <= qcnt + QW'(1);
            end
        end
    end

endmodule

// File: rtl/cs_strobe.sv
module cs_strobe
    import cs_pkg::*;
#(
    parameter int QW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nxt_live,
    input  logic [QW-1:0] nxt_q,
    input  acc_ctx_t      nxt_ctx,
    input  logic [QW-1:0] nxt_last,
    output logic          cs_n,
    output logic          we_n
);

    logic          in_window;
    logic [QW-1:0] tail_q;

    // Last active quarter; the access always spans at least four quarters
    assign tail_q    = nxt_last - QW'(nxt_ctx.early);
    assign in_window = nxt_live && nxt_ctx.hit
                    && (nxt_q >= QW'(nxt_ctx.lead))
                    && (nxt_q <= tail_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n <= 1'b1;
            we_n <= 1'b1;
        end else begin
            cs_n <= ~in_window;
            we_n <= ~(in_window && nxt_ctx.wr);
        end
    end

endmodule

// File: rtl/cs_timing_gen.sv
module cs_timing_gen
    import cs_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_start,
    input  logic [AW-1:0]     acc_addr,
    input  logic [TYPE_W-1:0] acc_type,
    input  logic              acc_write,
    input  logic [LW-1:0]     acc_len,
    input  logic [AW-1:0]     cfg_base,
    input  logic [AW-1:0]     cfg_amask,
    input  logic [TYPE_W-1:0] cfg_tbase,
    input  logic [TYPE_W-1:0] cfg_tmask,
    input  logic [1:0]        cfg_setup,
    input  logic              cfg_early,
    output logic              cs_n,
    output logic              we_n,
    output logic              acc_busy,
    output logic              acc_hit
);

    localparam int QW = LW + 2;

    logic          hit_now;
    logic          busy;
    acc_ctx_t      ctx_q;
    logic          nxt_live;
    logic [QW-1:0] nxt_q;
    acc_ctx_t      nxt_ctx;
    logic [QW-1:0] nxt_last;

    cs_match #(.AW(AW)) u_match (
        .addr  (acc_addr),
        .base  (cfg_base),
        .amask (cfg_amask),
        .atype (acc_type),
        .tbase (cfg_tbase),
        .tmask (cfg_tmask),
        .hit   (hit_now)
    );

    cs_seq #(.LW(LW), .QW(QW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .acc_start (acc_start),
        .hit_in    (hit_now),
        .wr_in     (acc_write),
        .setup_in  (cfg_setup),
        .early_in  (cfg_early),
        .len_in    (acc_len),
        .busy      (busy),
        .ctx_q     (ctx_q),
        .nxt_live  (nxt_live),
        .nxt_q     (nxt_q),
        .nxt_ctx   (nxt_ctx),
        .nxt_last  (nxt_last)
    );

    cs_strobe #(.QW(QW)) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .nxt_live (nxt_live),
        .nxt_q    (nxt_q),
        .nxt_ctx  (nxt_ctx),
        .nxt_last (nxt_last),
        .cs_n     (cs_n),
        .we_n     (we_n)
    );

    assign acc_busy = busy;
    assign acc_hit  = busy && ctx_q.hit;

endmodule

// File: rtl/cs_timing_chk.sv
module cs_timing_chk (
    input logic clk,
    input logic rst,
    input logic acc_start,
    input logic cs_n,
    input logic we_n,
    input logic acc_busy,
    input logic acc_hit
);

    AST_WE_WITHIN_CS: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !cs_n); // R6

    AST_CS_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> (acc_busy && acc_hit)); // R9

    AST_IDLE_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(acc_busy) |-> (cs_n && we_n)); // R4

    AST_SETUP_BOUND: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> ($past(acc_start) || $past(acc_start, 2) || $past(acc_start, 3))); // R3

    AST_HIT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (acc_busy && $past(acc_busy) && !$past(acc_start)) |-> $stable(acc_hit)); // R7

endmodule

bind cs_timing_gen cs_timing_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_start (acc_start),
    .cs_n      (cs_n),
    .we_n      (we_n),
    .acc_busy  (acc_busy),
    .acc_hit   (acc_hit)
);

// File: tb/cs_timing_gen_test.sv
module cs_timing_gen_test;

    localparam int AW = 16;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_start = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [2:0]    acc_type = '0;
    logic          acc_write = 1'b0;
    logic [LW-1:0] acc_len = LW'(1);
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_amask = '0;
    logic [2:0]    cfg_tbase = '0;
    logic [2:0]    cfg_tmask = '0;
    logic [1:0]    cfg_setup = '0;
    logic          cfg_early = 1'b0;
    logic          cs_n, we_n, acc_busy, acc_hit;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cs_timing_gen #(.AW(AW), .LW(LW)) uut (
        .clk(clk), .rst(rst), .acc_start(acc_start), .acc_addr(acc_addr),
        .acc_type(acc_type), .acc_write(acc_write), .acc_len(acc_len),
        .cfg_base(cfg_base), .cfg_amask(cfg_amask), .cfg_tbase(cfg_tbase),
        .cfg_tmask(cfg_tmask), .cfg_setup(cfg_setup), .cfg_early(cfg_early),
        .cs_n(cs_n), .we_n(we_n), .acc_busy(acc_busy), .acc_hit(acc_hit)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [15:0] base;
        logic [15:0] amask;
        logic [2:0]  atype;
        logic [2:0]  tbase;
        logic [2:0]  tmask;
        logic        exp_hit;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{16'h1234, 16'h1234, 16'hFFFF, 3'd0, 3'd0, 3'd0, 1'b1},
        '{16'h1235, 16'h1234, 16'hFFFF, 3'd0, 3'd0, 3'd0, 1'b0},
        '{16'h1235, 16'h1234, 16'hFFFE, 3'd0, 3'd0, 3'd0, 1'b1},
        '{16'hA357, 16'hA050, 16'hF0F0, 3'd0, 3'd0, 3'd0, 1'b1},
        '{16'hB050, 16'hA050, 16'hF0F0, 3'd0, 3'd0, 3'd0, 1'b0},
        '{16'hA0F0, 16'hA050, 16'hF0F0, 3'd0, 3'd0, 3'd0, 1'b0},
        '{16'h0000, 16'h0000, 16'h0000, 3'b101, 3'b100, 3'b110, 1'b1},
        '{16'h0000, 16'h0000, 16'h0000, 3'b111, 3'b100, 3'b110, 1'b0},
        '{16'hFFFF, 16'h1234, 16'h0000, 3'b111, 3'b000, 3'b000, 1'b1},
        '{16'h8000, 16'h0000, 16'h8000, 3'b010, 3'b010, 3'b111, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drives a one-cycle start; returns in quarter 0 of the access
    task automatic begin_access(input logic [AW-1:0] a, input logic [2:0] t,
                                input logic wr, input logic [LW-1:0] len);
        @(negedge clk);
        acc_addr  = a;
        acc_type  = t;
        acc_write = wr;
        acc_len   = len;
        acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
    endtask

    task automatic idle_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R3/R4/R5/R6: waveform of both strobes over every quarter of one access
    task automatic shape(input logic [1:0] su, input logic early, input logic wr,
                         input int len);
        int lead;
        int total;
        logic act;
        lead  = (su == 2'b10) ? 1 : (su == 2'b11) ? 2 : 0;
        total = 4 * len;
        cfg_amask = '0;
        cfg_tmask = '0;
        cfg_setup = su;
        cfg_early = early;
        begin_access(16'h4242, 3'd0, wr, LW'(len));
        for (int j = 0; j <= total; j++) begin
            act = (j < total) && (j >= lead) && (j <= total - 1 - int'(early));
            check($sformatf("R3 R4 R5 cs_n su=%0d early=%0d len=%0d q=%0d", su, early, len, j),
                  32'(cs_n), 32'(!act));
            check($sformatf("R6 we_n wr=%0d su=%0d q=%0d", wr, su, j),
                  32'(we_n), 32'(!(act && wr)));
            check($sformatf("R4 busy len=%0d q=%0d", len, j),
                  32'(acc_busy), 32'(j < total));
            if (j < total) @(negedge clk);
        end
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic exp_hit;

        // R10: reset state
        idle_wait(3);
        check("R10 cs_n in reset", 32'(cs_n), 32'd1);
        check("R10 we_n in reset", 32'(we_n), 32'd1);
        check("R10 busy in reset", 32'(acc_busy), 32'd0);
        rst = 1'b0;
        idle_wait(2);
        check("R10 cs_n after reset", 32'(cs_n), 32'd1);
        check("R10 hit after reset", 32'(acc_hit), 32'd0);

        // R1/R2: vector table
        for (int v = 0; v < 10; v++) begin
            cfg_base  = VECS[v].base;
            cfg_amask = VECS[v].amask;
            cfg_tbase = VECS[v].tbase;
            cfg_tmask = VECS[v].tmask;
            cfg_setup = 2'b00;
            begin_access(VECS[v].addr, VECS[v].atype, 1'b0, LW'(1));
            check($sformatf("R1 R2 table hit v=%0d", v), 32'(acc_hit), 32'(VECS[v].exp_hit));
            check($sformatf("R9 table cs_n v=%0d", v), 32'(cs_n), 32'(!VECS[v].exp_hit));
            idle_wait(4);
        end

        // R1: walking bit over the address mask
        cfg_tmask = '0;
        for (int b = 0; b < AW; b++) begin
            for (int m = 0; m < 2; m++) begin
                cfg_base  = 16'h5A3C;
                cfg_amask = (m == 1) ? (AW'(1) << b) : ~(AW'(1) << b);
                begin_access(16'h5A3C ^ (AW'(1) << b), 3'd0, 1'b0, LW'(1));
                check($sformatf("R1 walk bit=%0d mask_set=%0d", b, m), 32'(acc_hit), 32'(m == 0));
                idle_wait(4);
            end
        end

        // R2: exhaustive type sweep, address fully masked out
        cfg_amask = '0;
        for (int tm = 0; tm < 8; tm++) begin
            for (int tb = 0; tb < 8; tb++) begin
                for (int ty = 0; ty < 8; ty++) begin
                    cfg_tmask = 3'(tm);
                    cfg_tbase = 3'(tb);
                    exp_hit = ((3'(ty) ^ 3'(tb)) & 3'(tm)) == 3'd0;
                    begin_access(16'h0, 3'(ty), 1'b0, LW'(1));
                    check($sformatf("R2 type tm=%0d tb=%0d ty=%0d", tm, tb, ty),
                          32'(acc_hit), 32'(exp_hit));
                    idle_wait(4);
                end
            end
        end

        // R3/R4/R5/R6: every setup code, both negation settings, lengths 1 and 2
        for (int su = 0; su < 4; su++)
            for (int e = 0; e < 2; e++)
                for (int wr = 0; wr < 2; wr++)
                    for (int len = 1; len <= 2; len++) begin
                        shape(2'(su), e[0], wr[0], len);
                        idle_wait(1);
                    end

        // R4: length 0 behaves as 1
        cfg_setup = 2'b00;
        cfg_early = 1'b0;
        begin_access(16'h0, 3'd0, 1'b1, LW'(0));
        idle_wait(3);
        check("R4 len0 q3 cs_n", 32'(cs_n), 32'd0);
        check("R4 len0 q3 busy", 32'(acc_busy), 32'd1);
        idle_wait(1);
        check("R4 len0 q4 cs_n", 32'(cs_n), 32'd1);
        check("R4 len0 q4 busy", 32'(acc_busy), 32'd0);
        idle_wait(2);

        // R7: settings change mid-access
        cfg_base  = 16'h1000;
        cfg_amask = 16'hFFFF;
        cfg_setup = 2'b11;
        begin_access(16'h1000, 3'd0, 1'b0, LW'(1));
        cfg_setup = 2'b00;
        cfg_base  = 16'h2000;
        cfg_early = 1'b1;
        check("R7 q0 hit kept", 32'(acc_hit), 32'd1);
        idle_wait(1);
        check("R7 q1 setup kept", 32'(cs_n), 32'd1);
        idle_wait(1);
        check("R7 q2 cs active", 32'(cs_n), 32'd0);
        idle_wait(1);
        check("R7 q3 early not applied", 32'(cs_n), 32'd0);
        cfg_early = 1'b0;
        idle_wait(3);

        // R8: start in mid-access is ignored
        cfg_base  = 16'h1000;
        cfg_setup = 2'b00;
        begin_access(16'h1000, 3'd0, 1'b0, LW'(2));
        idle_wait(2);
        acc_addr  = 16'h3000;
        acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        check("R8 mid start ignored hit", 32'(acc_hit), 32'd1);
        check("R8 mid start ignored cs_n", 32'(cs_n), 32'd0);
        idle_wait(4);
        check("R8 q7 still busy", 32'(acc_busy), 32'd1);
        idle_wait(1);
        check("R8 q8 idle", 32'(acc_busy), 32'd0);
        idle_wait(2);

        // R8: start in the final quarter chains hit -> miss
        begin_access(16'h1000, 3'd0, 1'b0, LW'(1));
        idle_wait(3);
        acc_addr  = 16'h3000;
        acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        check("R8 chained miss hit", 32'(acc_hit), 32'd0);
        check("R8 chained busy", 32'(acc_busy), 32'd1);
        check("R9 chained miss cs_n", 32'(cs_n), 32'd1);
        idle_wait(3);
        check("R9 miss still busy q3", 32'(acc_busy), 32'd1);
        // R8: miss -> hit chained
        acc_addr  = 16'h1000;
        acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        check("R8 chained hit", 32'(acc_hit), 32'd1);
        check("R8 chained hit cs_n q0", 32'(cs_n), 32'd0);
        idle_wait(4);
        check("R8 chain ends", 32'(acc_busy), 32'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule